// File: doc/BRIEF.md
# I/O Window Address Translator

This block connects a processor-side memory bus to an ISA-style I/O port bus. It claims an 8 MB physical window at 0x80000000 to 0x807FFFFF. For each request that falls inside the window it forms an I/O port number and forwards the access. A map-mode input selects between two translations. Contiguous mode takes the low 16 address bits directly. Non-contiguous mode packs page-spaced addresses into port numbers, so that each port can sit on its own 4 KB page.

When the processor side is big-endian, the block reorders byte lanes on both the write data and the returned read data. Halfword accesses swap their two low bytes. Word accesses reverse all four bytes. Byte accesses pass through untouched.

The request path is purely combinational. The read return is combinational by default. A parameter can select a registered read return for timing-critical placements. The map-mode and endian inputs come from registers elsewhere. The map-mode register resets to contiguous.

Top module: `iowin_xlate`

## Requirements
- R1: A request is claimed exactly when `cpu_addr[31:23]` equals 9'h100, which covers addresses 0x80000000 through 0x807FFFFF inclusive.
- R2: With `map_noncontig` = 0, `io_port` equals `cpu_addr[15:0]` for every claimed request.
- R3: With `map_noncontig` = 1, `io_port` equals `(cpu_addr & 0x1F) | ((cpu_addr & 0x07FFF000) >> 7)`. This places address bits 22..12 at port bits 15..5 and address bits 4..0 at port bits 4..0.
- R4: `io_rd` and `io_wr` follow `cpu_rd` and `cpu_wr` only for claimed requests. A strobe outside the window raises `cpu_noclaim` and leaves both I/O strobes low. `cpu_noclaim` is low when no strobe is active.
- R5: `io_size` equals `cpu_size` in every cycle. The encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved.
- R6: With `big_endian` = 0, or with a size of byte (0) or reserved (3), data passes unchanged in both directions.
- R7: With `big_endian` = 1 and size halfword (1), bits 7..0 and 15..8 trade places and bits 31..16 pass unchanged. This applies both from `cpu_wdata` to `io_wdata` and from `io_rdata` to `cpu_rdata`.
- R8: With `big_endian` = 1 and size word (2), the four bytes are reversed in both directions: byte 0 swaps with byte 3, and byte 1 swaps with byte 2.
- R9: With `REG_RDATA` = 0, `cpu_rdata` presents the lane-ordered `io_rdata` in the same cycle as a claimed read. In every other cycle it is zero.
- R10: With `REG_RDATA` = 1, `cpu_rdata` resets to zero. It loads the lane-ordered `io_rdata` at the clock edge that ends a claimed read, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the registered read return) |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_noncontig | input | 1 | 0 = contiguous map, 1 = non-contiguous map |
| big_endian | input | 1 | 1 = reorder byte lanes for a big-endian processor |
| cpu_addr | input | 32 | Processor physical address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 32 | Read data returned to the processor |
| cpu_noclaim | output | 1 | Strobe seen outside the window |
| io_port | output | 16 | Translated I/O port number |
| io_size | output | 2 | Forwarded access size |
| io_wdata | output | 32 | Lane-ordered write data |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_rdata | input | 32 | Read data from the I/O bus |

## Verification
Almost all of the block is combinational, so a fault in decode or in the lane ordering shows up at `io_port`, `io_wdata` or `cpu_rdata` in the same cycle as the request. A window decode error would appear as a wrong claim on the first access near either window edge. A wrong internal state is possible only in the registered read return: a missed load or a spurious load shows in `cpu_rdata` one edge after the read. The lost value then persists until the next claimed read. Because of this, the bench compares both read-return variants against its model on every clock, using unclaimed reads and idle cycles placed between loads.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/iowin_decode.sv
// Window claim and port formation.
module iowin_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          PORT_W   = 16,
  parameter int          WIN_BITS = 23,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          PAGE_LSB = 12,
  parameter int          KEEP_LO  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              noncontig,
  output logic              hit,
  output logic [PORT_W-1:0] port
);
  localparam int HI_W = WIN_BITS - PAGE_LSB;
  localparam int NC_W = HI_W + KEEP_LO;

  logic [NC_W-1:0]   packed_nc;
  logic [PORT_W-1:0] port_nc;
  logic [PORT_W-1:0] port_ct;

  // Compare only the bits above the window size
  assign hit = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

  // Page index bits drop onto the port bits just above the kept offset
  assign packed_nc = {addr[WIN_BITS-1:PAGE_LSB], addr[KEEP_LO-1:0]};
  assign port_nc   = PORT_W'(packed_nc);
  assign port_ct   = addr[PORT_W-1:0];

  always_comb begin
    if (noncontig) port = port_nc;
    else           port = port_ct;
  end
endmodule

// File: rtl/iowin_lane_swap.sv
// Size-dependent byte lane reordering; the same function serves both directions.
module iowin_lane_swap
  import iowin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              big_endian,
  input  xfer_size_e        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] rev_word;
  logic [DATA_W-1:0] swp_half;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_rev
      assign rev_word[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
    end
  endgenerate

  assign swp_half = {din[DATA_W-1:16], din[7:0], din[15:8]};

  always_comb begin
    dout = din;
    if (big_endian) begin
      unique case (size)
        SZ_HALF: dout = swp_half;
        SZ_WORD: dout = rev_word;
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/iowin_rdreg.sv
// Registered read return with explicit load enable.
module iowin_rdreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;
  logic              past_ok;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      past_ok <= 1'b0;
    end else begin
      q       <= q_nxt;
      past_ok <= 1'b1;
    end
  end

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ld)) |-> (q == $past(d)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ld)) |-> $stable(q));
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
  import iowin_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          PORT_W    = 16,
  parameter int          WIN_BITS  = 23,
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter bit          REG_RDATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_noncontig,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_noclaim,
  output logic [PORT_W-1:0] io_port,
  output logic [1:0]        io_size,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_rd,
  output logic              io_wr,
  input  logic [DATA_W-1:0] io_rdata
);
  localparam int PAGE_LSB = 12;
  localparam int KEEP_LO  = 5;
  localparam int TAG_W    = ADDR_W - WIN_BITS;

  xfer_size_e        size_e;
  logic              win_hit;
  logic              rd_claim;
  logic [DATA_W-1:0] rd_ordered;

  assign size_e = xfer_size_e'(cpu_size);

  iowin_decode #(
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W),
    .WIN_BITS(WIN_BITS),
    .WIN_BASE(WIN_BASE),
    .PAGE_LSB(PAGE_LSB),
    .KEEP_LO (KEEP_LO)
  ) u_decode (
    .addr     (cpu_addr),
    .noncontig(map_noncontig),
    .hit      (win_hit),
    .port     (io_port)
  );

  iowin_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .big_endian(big_endian),
    .size      (size_e),
    .din       (cpu_wdata),
    .dout      (io_wdata)
  );

  iowin_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .big_endian(big_endian),
    .size      (size_e),
    .din       (io_rdata),
    .dout      (rd_ordered)
  );

  assign io_size     = cpu_size;
  assign io_rd       = cpu_rd & win_hit;
  assign io_wr       = cpu_wr & win_hit;
  assign cpu_noclaim = (cpu_rd | cpu_wr) & ~win_hit;
  assign rd_claim    = cpu_rd & win_hit;

  generate
    if (REG_RDATA) begin : g_rd_reg
      iowin_rdreg #(.DATA_W(DATA_W)) u_rdreg (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (rd_claim),
        .d    (rd_ordered),
        .q    (cpu_rdata)
      );
    end else begin : g_rd_comb
      always_comb begin
        cpu_rdata = '0;
        if (rd_claim) cpu_rdata = rd_ordered;
      end
    end
  endgenerate

  // Any forwarded strobe must come from an address inside the window
  assert_claim_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]));

  assert_noclaim_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_noclaim |-> (!io_rd && !io_wr));

  assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd |-> cpu_rd) and (io_wr |-> cpu_wr));

  assert_contig_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && !map_noncontig) |-> (io_port == cpu_addr[PORT_W-1:0]));

  assert_noncontig_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && map_noncontig) |->
      (io_port[KEEP_LO-1:0] == cpu_addr[KEEP_LO-1:0]) &&
      (io_port[KEEP_LO +: (WIN_BITS-PAGE_LSB)] == cpu_addr[PAGE_LSB +: (WIN_BITS-PAGE_LSB)]));

  // An unclaimed window tag never forwards anything
  assert_tag_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: TAG_W] != WIN_BASE[ADDR_W-1 -: TAG_W]) |-> (!io_rd && !io_wr));
endmodule

// File: tb/tb_iowin_xlate.sv
`timescale 1ns/1ps
module tb_iowin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_noncontig = 1'b0;
  logic        big_endian = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] io_rdata = '0;

  logic [31:0] cpu_rdata, cpu_rdata_r, io_wdata, io_wdata_r;
  logic        cpu_noclaim, cpu_noclaim_r, io_rd, io_rd_r, io_wr, io_wr_r;
  logic [15:0] io_port, io_port_r;
  logic [1:0]  io_size, io_size_r;

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg = '0;

  always #5 clk = ~clk;

  iowin_xlate #(.REG_RDATA(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .map_noncontig(map_noncontig), .big_endian(big_endian),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_noclaim(cpu_noclaim),
    .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata));

  iowin_xlate #(.REG_RDATA(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .map_noncontig(map_noncontig), .big_endian(big_endian),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata_r), .cpu_noclaim(cpu_noclaim_r),
    .io_port(io_port_r), .io_size(io_size_r), .io_wdata(io_wdata_r),
    .io_rd(io_rd_r), .io_wr(io_wr_r), .io_rdata(io_rdata));

  // ---- behavioural reference ----
  function automatic bit m_hit(input logic [31:0] a);
    return (a >= 32'h8000_0000) && (a <= 32'h807F_FFFF);
  endfunction

  function automatic logic [15:0] m_port(input logic [31:0] a, input bit nc);
    logic [31:0] p;
    if (nc) p = (a & 32'h1F) | ((a & 32'h07FF_F000) >> 7);
    else    p = a & 32'hFFFF;
    return p[15:0];
  endfunction

  function automatic logic [31:0] m_swap(input logic [31:0] d, input bit be, input int sz);
    logic [7:0] by [4];
    logic [7:0] t;
    for (int i = 0; i < 4; i++) by[i] = d[8*i +: 8];
    if (be && sz == 1) begin
      t = by[0]; by[0] = by[1]; by[1] = t;
    end else if (be && sz == 2) begin
      t = by[0]; by[0] = by[3]; by[3] = t;
      t = by[1]; by[1] = by[2]; by[2] = t;
    end
    return {by[3], by[2], by[1], by[0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one request at negedge, check before the next posedge, then step the model
  task automatic step(input logic [31:0] a, input int sz, input bit rd, input bit wr,
                      input bit nc, input bit be, input logic [31:0] wd, input logic [31:0] rdd);
    bit h;
    logic [31:0] exp_rd;
    @(negedge clk);
    cpu_addr = a; cpu_size = sz[1:0]; cpu_rd = rd; cpu_wr = wr;
    map_noncontig = nc; big_endian = be; cpu_wdata = wd; io_rdata = rdd;
    #4;
    h = m_hit(a);
    chk("R1/R4", "io_rd", {31'd0, io_rd}, {31'd0, rd & h});
    chk("R1/R4", "io_wr", {31'd0, io_wr}, {31'd0, wr & h});
    chk("R4", "cpu_noclaim", {31'd0, cpu_noclaim}, {31'd0, (rd | wr) & !h});
    chk("R5", "io_size", {30'd0, io_size}, sz);
    if (h) begin
      if (nc) chk("R3", "io_port", {16'd0, io_port}, {16'd0, m_port(a, 1'b1)});
      else    chk("R2", "io_port", {16'd0, io_port}, {16'd0, m_port(a, 1'b0)});
    end
    if (!be || sz == 0 || sz == 3) chk("R6", "io_wdata", io_wdata, m_swap(wd, be, sz));
    else if (sz == 1)              chk("R7", "io_wdata", io_wdata, m_swap(wd, be, sz));
    else                           chk("R8", "io_wdata", io_wdata, m_swap(wd, be, sz));
    exp_rd = (rd && h) ? m_swap(rdd, be, sz) : 32'd0;
    chk("R9", "cpu_rdata comb", cpu_rdata, exp_rd);
    chk("R10", "cpu_rdata reg", cpu_rdata_r, mreg);
    chk("R4", "reg variant io_port", {16'd0, io_port_r}, {16'd0, io_port});
    @(posedge clk);
    if (rd && h) mreg = m_swap(rdd, be, sz);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    // reset state
    #3;
    chk("R10", "reset cpu_rdata reg", cpu_rdata_r, 32'd0);
    chk("R9", "reset cpu_rdata comb", cpu_rdata, 32'd0);
    chk("R4", "reset io_rd", {31'd0, io_rd}, 32'd0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // window edges (R1)
    step(32'h8000_0000, 0, 1, 0, 0, 0, 32'h11, 32'hA1B2C3D4);
    step(32'h807F_FFFF, 0, 1, 0, 1, 0, 32'h22, 32'h55667788);
    step(32'h8080_0000, 0, 1, 0, 0, 0, 32'h33, 32'h99AABBCC);
    step(32'h7FFF_FFFF, 2, 0, 1, 0, 1, 32'h44, 32'h12345678);
    step(32'h0000_0092, 2, 1, 0, 0, 0, 32'h0, 32'hDEADBEEF);
    // contiguous and non-contiguous ports (R2, R3)
    step(32'h8000_0398, 0, 0, 1, 0, 0, 32'h5A, 32'h0);
    step(32'h8039_8000, 0, 0, 1, 1, 0, 32'h5A, 32'h0);
    step(32'h8012_3FFF, 1, 1, 0, 1, 1, 32'h0, 32'hCAFEF00D);
    // endian halfword and word both directions (R7, R8)
    step(32'h8000_0010, 1, 0, 1, 0, 1, 32'hAABBCCDD, 32'h0);
    step(32'h8000_0020, 2, 1, 0, 0, 1, 32'h0, 32'h01020304);
    step(32'h8000_0024, 3, 1, 0, 0, 1, 32'h0, 32'h0A0B0C0D);
    // idle cycles: registered return holds (R10)
    step(32'h8000_0000, 2, 0, 0, 0, 0, 32'h0, 32'hFFFFFFFF);
    step(32'h9000_0000, 2, 1, 0, 0, 1, 32'h0, 32'hEEEEEEEE);

    for (int n = 0; n < 600; n++) begin
      a = $urandom;
      if ((n % 4) != 0) a = 32'h8000_0000 | (a & 32'h007F_FFFF);
      step(a, $urandom_range(0, 3), $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule